// File: doc/BRIEF.md
# Byte-Coded Register Machine

A small multi-cycle processor that runs straight-line programs made of one-byte instructions. It holds four 8-bit general registers and a program counter. Each instruction takes three clock cycles: the address goes out to a synchronous program memory, the returned byte is split into fields and executed, and the result is written back. A print operation reports a register index and its value on a one-cycle output strobe.

A pulse on `start_i` clears the registers and the program counter and runs the program from address 0. The machine stops on a halt instruction, or on one of the two unused opcodes. In that second case it also raises an illegal flag. A later start pulse runs the program again.

Top module: `byte_cpu`

## Requirements
- R1: After reset, and before any start pulse, `halted_o`, `illegal_o` and `out_valid_o` are 0, `imem_addr_o` is 0 and all four registers read as 0.
- R2: An instruction byte has three fields. Bits 7..5 are the opcode: 000 halt, 001 load, 010 move, 011 add, 100 subtract, 101 print, 110 and 111 unused. Bits 4..3 are the destination register. Bits 2..0 are the source field.
- R3: Load writes the source field, zero-extended to 8 bits, into the destination register.
- R4: Move copies into the destination the register selected by the low two bits of the source field. Bit 2 of that field is ignored.
- R5: Add sets dst = dst + src modulo 256.
- R6: Subtract sets dst = dst - src modulo 256. A result below zero wraps around.
- R7: Print raises `out_valid_o` for exactly one cycle, with `out_reg_o` equal to the destination index and `out_data_o` equal to that register's value. The pulse falls in the third cycle of the instruction.
- R8: Halt sets `halted_o`. After that, no print occurs and `imem_addr_o` stays constant until the next start.
- R9: Opcodes 110 and 111 set both `illegal_o` and `halted_o`, and execution stops.
- R10: Each instruction takes three cycles. `imem_addr_o` is the program counter: it starts at 0 and advances by one in the execute cycle of every instruction, including the one that stops the machine.
- R11: A start pulse in any cycle clears the registers, the program counter and both flags, and begins fetching at address 0. It takes priority over an instruction executing in the same cycle, so that instruction's halt or print has no effect.
- R12: The program 0x25, 0x2F, 0x61, 0xA0, 0x00 prints register 0 with value 12, then halts. `halted_o` rises 15 cycles after the start pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear state and run from address 0 |
| imem_addr_o | output | PC_W | Program memory address |
| imem_rdata_i | input | 8 | Program memory data, one cycle after the address |
| out_valid_o | output | 1 | Print strobe |
| out_reg_o | output | 2 | Printed register index |
| out_data_o | output | 8 | Printed register value |
| halted_o | output | 1 | Machine stopped |
| illegal_o | output | 1 | Stopped on an unused opcode |

## Verification
A start pulse can arrive in the same cycle that a halt or print instruction executes. The start must win, so the halt does not take effect and the print strobe is suppressed. The bench asserts `start_i` in the execute cycle of a halt and again in the execute cycle of a print. It then checks that `halted_o` stays low and that exactly one print appears, the one from the rerun. A behavioural model, compared with the outputs on every clock, judges the same collision cycle by cycle.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
  localparam int INS_W = 8;
  localparam int OP_W  = 3;
  localparam int RIDX_W = 2;
  localparam int FLD_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'b000,
    OP_LOAD  = 3'b001,
    OP_MOV   = 3'b010,
    OP_ADD   = 3'b011,
    OP_SUB   = 3'b100,
    OP_PRINT = 3'b101,
    OP_RSV6  = 3'b110,
    OP_RSV7  = 3'b111
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_EXEC,
    ST_WB,
    ST_STOP
  } state_e;

  typedef struct packed {
    opcode_e               op;
    logic [RIDX_W-1:0]     dst;
    logic [FLD_W-1:0]      fld;
  } decoded_t;
endpackage

// File: rtl/byte_cpu_decode.sv
module byte_cpu_decode
  import byte_cpu_pkg::*;
(
  input  logic [INS_W-1:0] ins_i,
  output decoded_t         dec_o,
  output logic             illegal_o
);
  always_comb begin
    dec_o.op  = opcode_e'(ins_i[7:5]);
    dec_o.dst = ins_i[4:3];
    dec_o.fld = ins_i[2:0];
  end

  assign illegal_o = (dec_o.op == OP_RSV6) || (dec_o.op == OP_RSV7);
endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu
  import byte_cpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opcode_e              op_i,
  input  logic [FLD_W-1:0]     fld_i,
  input  logic [DATA_W-1:0]    dst_val_i,
  input  logic [DATA_W-1:0]    src_val_i,
  output logic [DATA_W-1:0]    res_o,
  output logic                 we_o
);
  always_comb begin
    res_o = '0;
    we_o  = 1'b0;
    case (op_i)
      OP_LOAD: begin res_o = DATA_W'(fld_i);         we_o = 1'b1; end
      OP_MOV:  begin res_o = src_val_i;              we_o = 1'b1; end
      OP_ADD:  begin res_o = dst_val_i + src_val_i;  we_o = 1'b1; end
      OP_SUB:  begin res_o = dst_val_i - src_val_i;  we_o = 1'b1; end
      default: begin res_o = '0;                     we_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]  raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q[g] <= '0;
      else if (clr_i)                              q[g] <= '0;
      else if (we_i && (waddr_i == IDX_W'(g)))     q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = q[raddr_a_i];
  assign rdata_b_o = q[raddr_b_i];
endmodule

// File: rtl/byte_cpu_ctrl.sv
module byte_cpu_ctrl
  import byte_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  opcode_e             op_i,
  input  logic [RIDX_W-1:0]   dst_i,
  input  logic                illegal_i,
  input  logic                alu_we_i,
  input  logic [DATA_W-1:0]   alu_res_i,
  input  logic [DATA_W-1:0]   dst_val_i,
  output logic [PC_W-1:0]     pc_o,
  output logic                rf_clr_o,
  output logic                rf_we_o,
  output logic [RIDX_W-1:0]   rf_waddr_o,
  output logic [DATA_W-1:0]   rf_wdata_o,
  output logic                out_valid_o,
  output logic [RIDX_W-1:0]   out_reg_o,
  output logic [DATA_W-1:0]   out_data_o,
  output logic                halted_o,
  output logic                illegal_o
);
  state_e              state_q;
  logic [PC_W-1:0]     pc_q;
  logic                wb_we_q;
  logic [RIDX_W-1:0]   wb_dst_q;
  logic [DATA_W-1:0]   wb_data_q;
  logic                ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      pc_q        <= '0;
      wb_we_q     <= 1'b0;
      wb_dst_q    <= '0;
      wb_data_q   <= '0;
      ill_q       <= 1'b0;
      out_valid_o <= 1'b0;
      out_reg_o   <= '0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (start_i) begin
        // restart outranks whatever is executing this cycle
        state_q <= ST_FETCH;
        pc_q    <= '0;
        ill_q   <= 1'b0;
        wb_we_q <= 1'b0;
      end else begin
        case (state_q)
          ST_FETCH: state_q <= ST_EXEC;
          ST_EXEC: begin
            pc_q      <= pc_q + 1'b1;
            wb_dst_q  <= dst_i;
            wb_data_q <= alu_res_i;
            wb_we_q   <= alu_we_i;
            if (illegal_i) begin
              ill_q   <= 1'b1;
              state_q <= ST_STOP;
            end else if (op_i == OP_HALT) begin
              state_q <= ST_STOP;
            end else begin
              state_q <= ST_WB;
              if (op_i == OP_PRINT) begin
                out_valid_o <= 1'b1;
                out_reg_o   <= dst_i;
                out_data_o  <= dst_val_i;
              end
            end
          end
          ST_WB: begin
            state_q <= ST_FETCH;
            wb_we_q <= 1'b0;
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end

  assign pc_o       = pc_q;
  assign rf_clr_o   = start_i;
  assign rf_we_o    = (state_q == ST_WB) && wb_we_q;
  assign rf_waddr_o = wb_dst_q;
  assign rf_wdata_o = wb_data_q;
  assign halted_o   = (state_q == ST_STOP);
  assign illegal_o  = ill_q;
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import byte_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 8,
  parameter int NREG   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [PC_W-1:0]   imem_addr_o,
  input  logic [INS_W-1:0]  imem_rdata_i,
  output logic              out_valid_o,
  output logic [RIDX_W-1:0] out_reg_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              halted_o,
  output logic              illegal_o
);
  decoded_t            dec;
  logic                dec_ill;
  logic [DATA_W-1:0]   dst_val, src_val, alu_res;
  logic                alu_we;
  logic                rf_clr, rf_we;
  logic [RIDX_W-1:0]   rf_waddr;
  logic [DATA_W-1:0]   rf_wdata;

  byte_cpu_decode u_dec (
    .ins_i     (imem_rdata_i),
    .dec_o     (dec),
    .illegal_o (dec_ill)
  );

  byte_cpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (rf_clr),
    .we_i      (rf_we),
    .waddr_i   (rf_waddr),
    .wdata_i   (rf_wdata),
    .raddr_a_i (dec.dst),
    .rdata_a_o (dst_val),
    .raddr_b_i (dec.fld[RIDX_W-1:0]),
    .rdata_b_o (src_val)
  );

  byte_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i      (dec.op),
    .fld_i     (dec.fld),
    .dst_val_i (dst_val),
    .src_val_i (src_val),
    .res_o     (alu_res),
    .we_o      (alu_we)
  );

  byte_cpu_ctrl #(.DATA_W(DATA_W), .PC_W(PC_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .op_i        (dec.op),
    .dst_i       (dec.dst),
    .illegal_i   (dec_ill),
    .alu_we_i    (alu_we),
    .alu_res_i   (alu_res),
    .dst_val_i   (dst_val),
    .pc_o        (imem_addr_o),
    .rf_clr_o    (rf_clr),
    .rf_we_o     (rf_we),
    .rf_waddr_o  (rf_waddr),
    .rf_wdata_o  (rf_wdata),
    .out_valid_o (out_valid_o),
    .out_reg_o   (out_reg_o),
    .out_data_o  (out_data_o),
    .halted_o    (halted_o),
    .illegal_o   (illegal_o)
  );
endmodule

// File: rtl/byte_cpu_chk.sv
module byte_cpu_chk #(
  parameter int PC_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [PC_W-1:0] imem_addr_o,
  input logic            out_valid_o,
  input logic            halted_o,
  input logic            illegal_o
);
  // R7
  print_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  // R8
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !start_i) |=> (halted_o && $stable(imem_addr_o) && !out_valid_o));

  // R9
  illegal_stops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> halted_o);

  // R10
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ((imem_addr_o == $past(imem_addr_o)) ||
                  (imem_addr_o == PC_W'($past(imem_addr_o) + 1'b1))));

  // R11
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!halted_o && !illegal_o && !out_valid_o && imem_addr_o == '0));
endmodule

bind byte_cpu byte_cpu_chk #(.PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .imem_addr_o (imem_addr_o),
  .out_valid_o (out_valid_o),
  .halted_o    (halted_o),
  .illegal_o   (illegal_o)
);

// File: tb/byte_cpu_tb.sv
module byte_cpu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] addr;
  logic [7:0] rdata;
  logic       out_valid;
  logic [1:0] out_reg;
  logic [7:0] out_data;
  logic       halted;
  logic       illegal;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] mem [256];
  int got_q[$];

  always #4 clk = ~clk;

  byte_cpu u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .imem_addr_o(addr), .imem_rdata_i(rdata),
    .out_valid_o(out_valid), .out_reg_o(out_reg), .out_data_o(out_data),
    .halted_o(halted), .illegal_o(illegal)
  );

  always @(posedge clk) rdata <= mem[addr];

  // behavioural reference: 0 idle, 1 fetch, 2 execute, 3 write-back, 4 stopped
  int m_phase = 0, m_pc = 0, m_valid = 0, m_reg = 0, m_data = 0;
  int m_halt = 0, m_ill = 0, m_we = 0, m_dst = 0, m_res = 0;
  int m_r[4] = '{0, 0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_pc = 0; m_valid = 0; m_halt = 0; m_ill = 0; m_we = 0;
      m_r = '{0, 0, 0, 0};
    end else if (start) begin
      m_phase = 1; m_pc = 0; m_valid = 0; m_halt = 0; m_ill = 0; m_we = 0;
      m_r = '{0, 0, 0, 0};
    end else begin
      m_valid = 0;
      if (m_phase == 1) m_phase = 2;
      else if (m_phase == 2) begin
        int ins, op, fld, src;
        ins = mem[m_pc];
        m_pc = (m_pc + 1) % 256;
        op = ins / 32; m_dst = (ins / 8) % 4; fld = ins % 8; src = fld % 4;
        m_we = 1; m_phase = 3;
        case (op)
          0: begin m_we = 0; m_phase = 4; m_halt = 1; end
          1: m_res = fld;
          2: m_res = m_r[src];
          3: m_res = (m_r[m_dst] + m_r[src]) % 256;
          4: m_res = (m_r[m_dst] - m_r[src] + 256) % 256;
          5: begin m_we = 0; m_valid = 1; m_reg = m_dst; m_data = m_r[m_dst]; end
          default: begin m_we = 0; m_phase = 4; m_halt = 1; m_ill = 1; end
        endcase
      end else if (m_phase == 3) begin
        if (m_we != 0) m_r[m_dst] = m_res;
        m_phase = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check(out_valid == m_valid[0], "R7", "out_valid", int'(out_valid), m_valid);
      check(int'(addr) == m_pc, "R10", "imem_addr", int'(addr), m_pc);
      check(halted == m_halt[0], "R8", "halted", int'(halted), m_halt);
      check(illegal == m_ill[0], "R9", "illegal", int'(illegal), m_ill);
      if (out_valid) begin
        check(int'(out_reg) == m_reg, "R7", "out_reg", int'(out_reg), m_reg);
        check(int'(out_data) == m_data, "R7", "out_data", int'(out_data), m_data);
        got_q.push_back(int'(out_reg) * 256 + int'(out_data));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic load(input logic [7:0] prog[$]);
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    foreach (prog[i]) mem[i] = prog[i];
  endtask

  task automatic run(output int n);
    got_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    n = 1;
    while (!halted && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic expect_prints(input string req, input int exp[$]);
    check(got_q.size() == exp.size(), req, "print count", got_q.size(), exp.size());
    foreach (exp[i])
      if (i < got_q.size())
        check(got_q[i] == exp[i], req, "print reg*256+val", got_q[i], exp[i]);
  endtask

  initial begin
    int n;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!halted && !illegal && !out_valid, "R1", "flags after reset",
          int'({halted, illegal, out_valid}), 0);
    check(addr == 8'd0, "R1", "addr after reset", int'(addr), 0);

    // R12 / R2 example program
    load('{8'h25, 8'h2F, 8'h61, 8'hA0, 8'h00});
    run(n);
    expect_prints("R12", '{12});
    check(n == 15, "R12", "cycles to halt", n, 15);
    // R8 stopped machine holds address and stays halted
    repeat (10) @(negedge clk);
    check(halted && addr == 8'd5, "R8", "addr after halt", int'(addr), 5);
    expect_prints("R8", '{12});

    // R11 restart clears registers; R1 registers read zero
    load('{8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'h00});
    run(n);
    expect_prints("R11", '{0, 256, 512, 768});

    // R3 zero-extended immediate, R4 move ignores field bit 2
    load('{8'h37, 8'h5E, 8'hB8, 8'h2F, 8'hA8, 8'h00});
    run(n);
    expect_prints("R4", '{3*256+7, 256+7});

    // R5 add wraps, R6 subtract wraps below zero
    load('{8'h27, 8'h60, 8'h60, 8'h60, 8'h60, 8'h60, 8'h60, 8'hA0,
           8'h29, 8'h91, 8'hB0, 8'h00});
    run(n);
    expect_prints("R5", '{192, 2*256+255});
    check(n == 3*12, "R10", "cycles for 12 instructions", n, 36);

    // R9 opcode 110
    load('{8'h23, 8'hC0, 8'hA0, 8'h00});
    run(n);
    check(illegal && halted, "R9", "illegal 110", int'({illegal, halted}), 3);
    check(addr == 8'd2, "R9", "addr after 110", int'(addr), 2);
    expect_prints("R9", '{});
    // R9 opcode 111
    load('{8'hE0, 8'hA0, 8'h00});
    run(n);
    check(illegal && halted && addr == 8'd1, "R9", "illegal 111", int'(addr), 1);

    // R11 start coinciding with halt execute
    load('{8'h00});
    got_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(!halted && !illegal, "R11", "halt overridden by start", int'(halted), 0);
    repeat (5) @(negedge clk);
    check(halted, "R11", "halts after rerun", int'(halted), 1);

    // R11 start coinciding with print execute
    load('{8'h2D, 8'hA8, 8'h00});
    run(n);
    load('{8'hA0, 8'h00});
    got_q.delete();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (12) @(negedge clk);
    expect_prints("R11", '{0});
    check(halted, "R11", "halted after print rerun", int'(halted), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule